// File: doc/BRIEF.md
# Power-Up Reset Sequencer for a Serial-Link Controller

This block brings a serial-link controller and its PHY from a fully powered-down state to an operational state, one step at a time. A start request begins the sequence. The block enables the supply rail. It then turns on a chain of core clocks, one per cycle, and takes the PHY out of powerdown. After a fixed gap it enables the reference clock, and it then waits for the clocks to settle. Next it pulses the external device reset, whose active level is chosen by a configuration pin. At the end of that pulse it releases the PHY reset. It then polls the PLL-lock input at a fixed interval, with a bounded number of tries. The outcome is reported on `done_o` or `timeout_o`.

All delays are parameters counted in clock cycles, so a testbench can shrink them. One shared down-counter times every wait state. If a clock fails to enable, the block disables the clocks it has already turned on, in reverse order, and then turns the supply off. A shutdown request returns every output to its reset level within one cycle. The outputs are plain enable levels. Real clock gating and regulator control belong to the logic that consumes them.

Top module: `link_pwrup_seq`

## Requirements
- R1: After an accepted start, `supply_en_o` rises one cycle after the start edge. Then `clk_en_o` bits 0, 1, 2 rise on the following consecutive cycles. `phy_pwrdn_o` falls on the cycle after the last clock bit. No clock bit is on without the supply and the next-lower bit.
- R2: `ref_clk_en_o` rises exactly REF_GAP_CYC cycles after `phy_pwrdn_o` falls. It is never high while the PHY is powered down.
- R3: The external device reset asserts exactly SETTLE_CYC cycles after `ref_clk_en_o` rises.
- R4: The device reset stays asserted for exactly DEV_RST_CYC cycles. `dev_rst_o` is 1 when asserted if `dev_rst_act_high_i`=1, and 0 when asserted if it is 0. When not asserted it is the opposite level.
- R5: `phy_rst_o` (1 = PHY held in reset) falls on the same cycle the device reset deasserts. It is high whenever the device reset is asserted.
- R6: `pll_lock_i` is sampled every POLL_GAP_CYC cycles after PHY reset release. `done_o` rises on the first sample that sees lock, i.e. POLL_GAP_CYC*(n+1) cycles after release for sample n.
- R7: If none of MAX_POLLS samples sees lock, `timeout_o` rises POLL_GAP_CYC*MAX_POLLS cycles after release. On that cycle `phy_rst_o` re-asserts and `done_o` stays 0.
- R8: If `clk_fail_i[k]` is high when clock bit k would be enabled, bit k stays off. The clocks already on turn off one per cycle, highest index first. The supply turns off one cycle after the last clock. The block returns to idle without `done_o` and without asserting the device reset.
- R9: `shutdown_i` takes priority over `start_i`. On the next cycle the supply, all clocks and the reference clock are off. The PHY is powered down and held in reset, the device reset is deasserted, and `done_o`/`timeout_o` are 0.
- R10: `done_o` and `timeout_o` hold until a start or shutdown request. A start request while a sequence is running is ignored and does not change its timing. A start from the done or timeout state restarts the full sequence.
- R11: After reset, every enable is 0, the PHY is powered down and held in reset, the device reset is deasserted, and `done_o`/`timeout_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request to run the power-up sequence |
| shutdown_i | input | 1 | Request to return to the powered-down state |
| dev_rst_act_high_i | input | 1 | 1: device reset is active high; 0: active low |
| clk_fail_i | input | NUM_CLKS | Per-clock enable failure indication |
| pll_lock_i | input | 1 | PHY PLL lock status |
| supply_en_o | output | 1 | Supply rail enable |
| clk_en_o | output | NUM_CLKS | Core clock enables, bit 0 enabled first |
| phy_pwrdn_o | output | 1 | PHY powerdown (1 = powered down) |
| ref_clk_en_o | output | 1 | Reference clock enable |
| phy_rst_o | output | 1 | PHY reset (1 = held in reset) |
| dev_rst_o | output | 1 | External device reset at the configured polarity |
| done_o | output | 1 | Sequence completed with PLL locked |
| timeout_o | output | 1 | PLL lock never seen within the retry budget |

## Verification
Two corners are hard to reach from the ports. The first is a lock that arrives on exactly the last permitted poll. The second is a start request that lands in the middle of a running sequence. The bench watches for the falling edge of `phy_rst_o` and raises `pll_lock_i` half a poll interval before a chosen sample index. This places lock on sample 0, sample 2, the final sample, or never. The bench also pulses `start_i` during the settle wait and then checks that every later event time is unchanged. Clock-enable failures are injected at each position of the clock chain to observe the reverse unwind. Some runs are left in the done or timeout state so that the next run exercises a restart.

// File: rtl/pwrup_seq_pkg.sv
package pwrup_seq_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_PWR,
      ST_CLK,
      ST_PHYUP,
      ST_REFGAP,
      ST_SETTLE,
      ST_DEVRST,
      ST_POLL,
      ST_DONE,
      ST_TMO,
      ST_UNWIND
   } seq_state_e;

   function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                        input int unsigned c, input int unsigned d);
      int unsigned m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/pwrup_wait_ctr.sv
module pwrup_wait_ctr #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   output logic             zero_o
);

   generate
      if (CNT_W < 1) begin : g_bad_w
         $error("pwrup_wait_ctr: CNT_W must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt_q <= '0;
      else if (load_i)           cnt_q <= load_val_i;
      else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
   end

   assign zero_o = (cnt_q == '0);

   AST_CTR_PARKS_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (zero_o && !load_i) |=> zero_o); // R6

endmodule

// File: rtl/pwrup_retry_ctr.sv
module pwrup_retry_ctr #(
   parameter int unsigned MAX_TRIES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear_i,
   input  logic step_i,
   output logic last_o
);

   localparam int unsigned RW = (MAX_TRIES > 1) ? $clog2(MAX_TRIES) : 1;

   generate
      if (MAX_TRIES < 1) begin : g_bad_tries
         $error("pwrup_retry_ctr: MAX_TRIES must be at least 1");
      end
   endgenerate

   logic [RW-1:0] tries_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        tries_q <= '0;
      else if (clear_i)  tries_q <= '0;
      else if (step_i)   tries_q <= tries_q + 1'b1;
   end

   assign last_o = (32'(tries_q) == MAX_TRIES - 1);

   AST_NO_STEP_PAST_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      step_i |-> !last_o); // R7

   AST_TRIES_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      32'(tries_q) < MAX_TRIES); // R7

endmodule

// File: rtl/link_pwrup_seq.sv
module link_pwrup_seq
   import pwrup_seq_pkg::*;
#(
   parameter int unsigned NUM_CLKS     = 3,
   parameter int unsigned REF_GAP_CYC  = 2000,
   parameter int unsigned SETTLE_CYC   = 60000,
   parameter int unsigned DEV_RST_CYC  = 20000000,
   parameter int unsigned POLL_GAP_CYC = 20000,
   parameter int unsigned MAX_POLLS    = 2000
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic                shutdown_i,
   input  logic                dev_rst_act_high_i,
   input  logic [NUM_CLKS-1:0] clk_fail_i,
   input  logic                pll_lock_i,
   output logic                supply_en_o,
   output logic [NUM_CLKS-1:0] clk_en_o,
   output logic                phy_pwrdn_o,
   output logic                ref_clk_en_o,
   output logic                phy_rst_o,
   output logic                dev_rst_o,
   output logic                done_o,
   output logic                timeout_o
);

   localparam int unsigned MAX_DLY = max4(REF_GAP_CYC, SETTLE_CYC, DEV_RST_CYC, POLL_GAP_CYC);
   localparam int unsigned CW      = $clog2(MAX_DLY + 1);
   localparam int unsigned IW      = (NUM_CLKS > 1) ? $clog2(NUM_CLKS) : 1;

   generate
      if (NUM_CLKS < 1) begin : g_bad_clks
         $error("link_pwrup_seq: NUM_CLKS must be at least 1");
      end
      if (REF_GAP_CYC < 1 || SETTLE_CYC < 1 || DEV_RST_CYC < 1 || POLL_GAP_CYC < 1) begin : g_bad_dly
         $error("link_pwrup_seq: every delay must be at least one cycle");
      end
      if (MAX_POLLS < 1) begin : g_bad_polls
         $error("link_pwrup_seq: MAX_POLLS must be at least 1");
      end
   endgenerate

   seq_state_e          state_q;
   logic [IW-1:0]       clk_idx_q;
   logic                supply_q, pwrdn_q, ref_q, phy_rst_q, dev_act_q, done_q, tmo_q;
   logic [NUM_CLKS-1:0] clk_en_q;
   logic [NUM_CLKS-1:0] top_on;

   logic          ctr_load, ctr_zero;
   logic [CW-1:0] ctr_val;
   logic          try_clear, try_step, try_last;
   logic          start_ok;

   // Highest clock that is still on: the one the unwind removes next.
   for (genvar gi = 0; gi < NUM_CLKS; gi++) begin : g_unw
      if (gi == NUM_CLKS - 1) begin : g_msb
         assign top_on[gi] = clk_en_q[gi];
      end else begin : g_lsb
         assign top_on[gi] = clk_en_q[gi] & ~(|clk_en_q[NUM_CLKS-1:gi+1]);
      end
      if (gi > 0) begin : g_chain
         AST_CLK_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
            clk_en_q[gi] |-> clk_en_q[gi-1]); // R1
      end
   end

   assign start_ok = start_i &&
                     (state_q == ST_IDLE || state_q == ST_DONE || state_q == ST_TMO);

   // Shared wait timer: loaded on entry to each timed state with length-1.
   always_comb begin
      ctr_load = 1'b0;
      ctr_val  = '0;
      unique case (state_q)
         ST_PHYUP: begin
            ctr_load = 1'b1;
            ctr_val  = CW'(REF_GAP_CYC - 1);
         end
         ST_REFGAP: begin
            ctr_load = ctr_zero;
            ctr_val  = CW'(SETTLE_CYC - 1);
         end
         ST_SETTLE: begin
            ctr_load = ctr_zero;
            ctr_val  = CW'(DEV_RST_CYC - 1);
         end
         ST_DEVRST: begin
            ctr_load = ctr_zero;
            ctr_val  = CW'(POLL_GAP_CYC - 1);
         end
         ST_POLL: begin
            ctr_load = ctr_zero && !pll_lock_i && !try_last;
            ctr_val  = CW'(POLL_GAP_CYC - 1);
         end
         default: begin
            ctr_load = 1'b0;
            ctr_val  = '0;
         end
      endcase
   end

   assign try_clear = (state_q == ST_DEVRST) && ctr_zero;
   assign try_step  = (state_q == ST_POLL) && ctr_zero && !pll_lock_i && !try_last && !shutdown_i;

   pwrup_wait_ctr #(.CNT_W(CW)) u_wait (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (ctr_load),
      .load_val_i (ctr_val),
      .zero_o     (ctr_zero)
   );

   pwrup_retry_ctr #(.MAX_TRIES(MAX_POLLS)) u_retry (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (try_clear),
      .step_i  (try_step),
      .last_o  (try_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         clk_idx_q <= '0;
         supply_q  <= 1'b0;
         clk_en_q  <= '0;
         pwrdn_q   <= 1'b1;
         ref_q     <= 1'b0;
         phy_rst_q <= 1'b1;
         dev_act_q <= 1'b0;
         done_q    <= 1'b0;
         tmo_q     <= 1'b0;
      end else if (shutdown_i || start_ok) begin
         state_q   <= shutdown_i ? ST_IDLE : ST_PWR;
         clk_idx_q <= '0;
         supply_q  <= 1'b0;
         clk_en_q  <= '0;
         pwrdn_q   <= 1'b1;
         ref_q     <= 1'b0;
         phy_rst_q <= 1'b1;
         dev_act_q <= 1'b0;
         done_q    <= 1'b0;
         tmo_q     <= 1'b0;
      end else begin
         unique case (state_q)
            ST_PWR: begin
               supply_q  <= 1'b1;
               clk_idx_q <= '0;
               state_q   <= ST_CLK;
            end
            ST_CLK: begin
               if (clk_fail_i[clk_idx_q]) begin
                  state_q <= ST_UNWIND;
               end else begin
                  clk_en_q[clk_idx_q] <= 1'b1;
                  if (clk_idx_q == IW'(NUM_CLKS - 1)) state_q <= ST_PHYUP;
                  else                                clk_idx_q <= clk_idx_q + 1'b1;
               end
            end
            ST_PHYUP: begin
               pwrdn_q <= 1'b0;
               state_q <= ST_REFGAP;
            end
            ST_REFGAP: begin
               if (ctr_zero) begin
                  ref_q   <= 1'b1;
                  state_q <= ST_SETTLE;
               end
            end
            ST_SETTLE: begin
               if (ctr_zero) begin
                  dev_act_q <= 1'b1;
                  state_q   <= ST_DEVRST;
               end
            end
            ST_DEVRST: begin
               if (ctr_zero) begin
                  dev_act_q <= 1'b0;
                  phy_rst_q <= 1'b0;
                  state_q   <= ST_POLL;
               end
            end
            ST_POLL: begin
               if (ctr_zero) begin
                  if (pll_lock_i) begin
                     done_q  <= 1'b1;
                     state_q <= ST_DONE;
                  end else if (try_last) begin
                     tmo_q     <= 1'b1;
                     phy_rst_q <= 1'b1;
                     state_q   <= ST_TMO;
                  end
               end
            end
            ST_UNWIND: begin
               if (|clk_en_q) begin
                  clk_en_q <= clk_en_q & ~top_on;
               end else begin
                  supply_q <= 1'b0;
                  state_q  <= ST_IDLE;
               end
            end
            default: begin
               state_q <= state_q;
            end
         endcase
      end
   end

   assign supply_en_o  = supply_q;
   assign clk_en_o     = clk_en_q;
   assign phy_pwrdn_o  = pwrdn_q;
   assign ref_clk_en_o = ref_q;
   assign phy_rst_o    = phy_rst_q;
   assign dev_rst_o    = dev_rst_act_high_i ? dev_act_q : ~dev_act_q;
   assign done_o       = done_q;
   assign timeout_o    = tmo_q;

   AST_SUPPLY_UNDER_CLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (|clk_en_q) |-> supply_q); // R1

   AST_REF_NEEDS_PHY_UP: assert property (@(posedge clk) disable iff (!rst_n)
      ref_q |-> !pwrdn_q); // R2

   AST_DEVRST_AFTER_REF: assert property (@(posedge clk) disable iff (!rst_n)
      dev_act_q |-> ref_q); // R3

   AST_PHY_HELD_DURING_DEVRST: assert property (@(posedge clk) disable iff (!rst_n)
      dev_act_q |-> phy_rst_q); // R5

   AST_DONE_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_q) |-> $past(pll_lock_i)); // R6

   AST_DONE_TMO_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_q && tmo_q)); // R7

   AST_SHUTDOWN_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      shutdown_i |=> (!supply_q && pwrdn_q && !ref_q && phy_rst_q && !done_q && !tmo_q)); // R9

   AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && !start_i && !shutdown_i) |=> done_q); // R10

endmodule

// File: tb/link_pwrup_seq_tb_top.sv
`timescale 1ns/1ps
module link_pwrup_seq_tb_top;

   localparam int NCLK = 3;
   localparam int GAP  = 3;
   localparam int SETL = 5;
   localparam int DEVC = 8;
   localparam int POLL = 4;
   localparam int MAXP = 5;
   localparam int RUNC = 60;

   // Vector fields: [8] polarity, [7:5] clock fail mask, [4:2] lock sample (7 = never),
   // [1] keep final state (no shutdown), [0] start pulse while busy.
   localparam int NVEC = 7;
   localparam logic [8:0] VEC [NVEC] = '{
      {1'b1, 3'b000, 3'd0, 1'b0, 1'b0},
      {1'b0, 3'b000, 3'd2, 1'b1, 1'b1},
      {1'b1, 3'b000, 3'd7, 1'b1, 1'b0},
      {1'b0, 3'b010, 3'd0, 1'b0, 1'b0},
      {1'b1, 3'b001, 3'd0, 1'b0, 1'b0},
      {1'b0, 3'b100, 3'd4, 1'b0, 1'b0},
      {1'b1, 3'b000, 3'd4, 1'b0, 1'b1}
   };

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            start_i = 1'b0;
   logic            shutdown_i = 1'b0;
   logic            pol_i = 1'b1;
   logic [NCLK-1:0] fail_i = '0;
   logic            lock_i = 1'b0;
   logic            supply_en_o, phy_pwrdn_o, ref_clk_en_o, phy_rst_o, dev_rst_o, done_o, timeout_o;
   logic [NCLK-1:0] clk_en_o;

   int checks = 0;
   int failures = 0;

   always #2.5 clk = ~clk;

   link_pwrup_seq #(
      .NUM_CLKS(NCLK), .REF_GAP_CYC(GAP), .SETTLE_CYC(SETL),
      .DEV_RST_CYC(DEVC), .POLL_GAP_CYC(POLL), .MAX_POLLS(MAXP)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .shutdown_i(shutdown_i),
      .dev_rst_act_high_i(pol_i), .clk_fail_i(fail_i), .pll_lock_i(lock_i),
      .supply_en_o(supply_en_o), .clk_en_o(clk_en_o), .phy_pwrdn_o(phy_pwrdn_o),
      .ref_clk_en_o(ref_clk_en_o), .phy_rst_o(phy_rst_o), .dev_rst_o(dev_rst_o),
      .done_o(done_o), .timeout_o(timeout_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic chk_off(input string req);
      chk(supply_en_o == 1'b0 && clk_en_o == '0 && ref_clk_en_o == 1'b0, req,
          {supply_en_o, clk_en_o, ref_clk_en_o}, 0);
      chk(phy_pwrdn_o == 1'b1 && phy_rst_o == 1'b1, req, {phy_pwrdn_o, phy_rst_o}, 3);
      chk(done_o == 1'b0 && timeout_o == 1'b0, req, {done_o, timeout_o}, 0);
      chk(dev_rst_o == ~pol_i, req, dev_rst_o, ~pol_i);
   endtask

   task automatic run_vec(input logic [8:0] v);
      logic       pol, keep, busy;
      logic [2:0] fmask;
      int         lockn, k;
      int         t_sup_r, t_sup_f, t_pd_f, t_ref_r, t_dev_a, t_dev_d, t_phy_f, t_phy_r, t_done, t_tmo;
      int         t_clk_r [NCLK];
      int         t_clk_f [NCLK];
      logic       p_sup, p_pd, p_ref, p_dev, p_phy, p_done, p_tmo;
      logic [NCLK-1:0] p_clk;
      pol = v[8]; fmask = v[7:5]; lockn = int'(v[4:2]); keep = v[1]; busy = v[0];
      t_sup_r = -1; t_sup_f = -1; t_pd_f = -1; t_ref_r = -1; t_dev_a = -1;
      t_dev_d = -1; t_phy_f = -1; t_phy_r = -1; t_done = -1; t_tmo = -1;
      for (int j = 0; j < NCLK; j++) begin t_clk_r[j] = -1; t_clk_f[j] = -1; end
      @(negedge clk);
      pol_i = pol; fail_i = fmask; lock_i = 1'b0;
      @(negedge clk);
      p_sup = supply_en_o; p_clk = clk_en_o; p_pd = phy_pwrdn_o; p_ref = ref_clk_en_o;
      p_dev = dev_rst_o; p_phy = phy_rst_o; p_done = done_o; p_tmo = timeout_o;
      start_i = 1'b1;
      for (int c = 1; c <= RUNC; c++) begin
         @(negedge clk);
         start_i = (busy && c == 10);
         if (supply_en_o && !p_sup) t_sup_r = c;
         if (!supply_en_o && p_sup) t_sup_f = c;
         for (int j = 0; j < NCLK; j++) begin
            if (clk_en_o[j] && !p_clk[j]) t_clk_r[j] = c;
            if (!clk_en_o[j] && p_clk[j]) t_clk_f[j] = c;
         end
         if (!phy_pwrdn_o && p_pd) t_pd_f = c;
         if (ref_clk_en_o && !p_ref) t_ref_r = c;
         if (dev_rst_o == pol && p_dev != pol) t_dev_a = c;
         if (dev_rst_o != pol && p_dev == pol) t_dev_d = c;
         if (!phy_rst_o && p_phy) t_phy_f = c;
         if (phy_rst_o && !p_phy) t_phy_r = c;
         if (done_o && !p_done) t_done = c;
         if (timeout_o && !p_tmo) t_tmo = c;
         if (t_phy_f > 0 && lockn != 7 && c == t_phy_f + POLL * (lockn + 1) - 2) lock_i = 1'b1;
         p_sup = supply_en_o; p_clk = clk_en_o; p_pd = phy_pwrdn_o; p_ref = ref_clk_en_o;
         p_dev = dev_rst_o; p_phy = phy_rst_o; p_done = done_o; p_tmo = timeout_o;
      end
      if (fmask == 3'b000) begin
         chk(t_sup_r == 2, "R1 supply rise", t_sup_r, 2);
         for (int j = 0; j < NCLK; j++)
            chk(t_clk_r[j] == 3 + j, "R1 clock rise", t_clk_r[j], 3 + j);
         chk(t_pd_f == 3 + NCLK, "R1 phy power-up", t_pd_f, 3 + NCLK);
         chk(t_ref_r == t_pd_f + GAP, "R2 ref gap", t_ref_r, t_pd_f + GAP);
         chk(t_dev_a == t_ref_r + SETL, "R3 settle", t_dev_a, t_ref_r + SETL);
         chk(t_dev_d == t_dev_a + DEVC, "R4 pulse width", t_dev_d, t_dev_a + DEVC);
         chk(t_phy_f == t_dev_d, "R5 phy release", t_phy_f, t_dev_d);
         if (lockn != 7) begin
            chk(t_done == t_phy_f + POLL * (lockn + 1), "R6 done time", t_done, t_phy_f + POLL * (lockn + 1));
            chk(done_o == 1'b1 && timeout_o == 1'b0, "R10 done held", {done_o, timeout_o}, 2);
         end else begin
            chk(t_tmo == t_phy_f + POLL * MAXP, "R7 timeout time", t_tmo, t_phy_f + POLL * MAXP);
            chk(t_phy_r == t_tmo, "R7 phy re-reset", t_phy_r, t_tmo);
            chk(done_o == 1'b0 && timeout_o == 1'b1, "R7 flags held", {done_o, timeout_o}, 1);
         end
      end else begin
         k = 0;
         while (!fmask[k]) k++;
         chk(t_sup_r == 2, "R8 supply rise", t_sup_r, 2);
         chk(t_clk_r[k] == -1, "R8 failed clock stays off", t_clk_r[k], -1);
         if (k > 0) chk(t_clk_f[k-1] == 4 + k, "R8 top clock off first", t_clk_f[k-1], 4 + k);
         chk(t_sup_f == 4 + 2 * k, "R8 supply off last", t_sup_f, 4 + 2 * k);
         chk(t_dev_a == -1 && done_o == 1'b0 && phy_pwrdn_o == 1'b1, "R8 idle after unwind",
             {t_dev_a == -1, done_o, phy_pwrdn_o}, 5);
      end
      if (!keep) begin
         shutdown_i = 1'b1;
         @(negedge clk);
         shutdown_i = 1'b0;
         chk_off("R9 shutdown");
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk_off("R11 reset state");
      pol_i = 1'b0;
      @(negedge clk);
      chk(dev_rst_o == 1'b1, "R4 idle level active-low", dev_rst_o, 1);
      pol_i = 1'b1;
      @(negedge clk);
      chk(dev_rst_o == 1'b0, "R4 idle level active-high", dev_rst_o, 0);

      for (int i = 0; i < NVEC; i++) run_vec(VEC[i]);

      // Shutdown arriving together with start mid-sequence: shutdown wins.
      fail_i = '0; lock_i = 1'b0;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      repeat (8) @(negedge clk);
      chk(ref_clk_en_o == 1'b1, "R2 ref on before shutdown", ref_clk_en_o, 1);
      shutdown_i = 1'b1; start_i = 1'b1;
      @(negedge clk);
      shutdown_i = 1'b0; start_i = 1'b0;
      chk_off("R9 shutdown beats start");
      repeat (6) @(negedge clk);
      chk(supply_en_o == 1'b0, "R9 no restart after shutdown", supply_en_o, 0);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule